// File: doc/BRIEF.md
# PWM Break and Output Protection Controller

This block sits between a timer's complementary PWM channel pair and the output pins. It watches a set of fault inputs and merges them into a single break condition. The fault inputs are an external pin, a comparator output and five system faults. When a break is present, the main output enable is removed from the outputs in the same cycle, without waiting for a clock edge. The enable register is then cleared at the next edge. Each output then either drives a programmable safe level or is released to high impedance.

Software controls the block through a two-word register port. One word holds the break enable, the break polarity, a 4-bit glitch filter setting and the idle-drive select. The other word holds the main output enable, the two shutdown levels and a sticky break flag. The pin source and the comparator source each have their own enable and polarity, supplied on input ports. Whatever the inputs and settings, the two complementary outputs are never both driven high together.

Top module: `pwm_guard`

## Requirements
- R1: After reset, break detection is off, the main output enable is 0, the break flag is 0, the idle-drive select is 0, and both register words read as 0. Both output enables are 0.
- R2: Register word 0 is written when `regAddr`=0. Bit 0 is the break enable, bit 1 is the break polarity (1 = active high), bits 5:2 are the filter setting and bit 6 is idle-drive. A write to bits 1:0 takes effect one clock after the write edge, so a read in the half cycle after the write still returns the old value.
- R3: The source term is the OR of the pin term and the comparator term. The pin term is `extEn & (extPin == extPol)` and the comparator term is `cmpEn & (cmpIn == cmpPol)`. With the break enabled, a break is present when the source term equals the break polarity bit, or when any `sysFault` bit is 1. The system faults are not subject to polarity or filtering. With the break disabled, no break ever occurs.
- R4: For a filter setting f, the polarised source term must be asserted for 2^f consecutive clock samples before it counts as a break. A shorter assertion is ignored and leaves the flag at 0. A setting of 0 passes the term straight through.
- R5: A break removes the main output enable from the outputs in the same cycle, combinationally. The main output enable register reads 0 after the next clock edge.
- R6: Every clock edge with a break present sets the break flag, which is bit 7 of word 1. Writing word 1 with bit 7 = 1 clears the flag. Writing 0 to bit 7 has no effect.
- R7: Word 1 is written when `regAddr`=1. Bit 0 sets or clears the main output enable, and bits 1 and 2 are the shutdown levels for `outCh` and `outChN`. A write of bit 0 = 1 while a break is present leaves the main output enable at 0.
- R8: Bit 0 of read word 1 is the effective main output enable passed through two flip-flops. It reflects a change two clock edges after the change.
- R9: While the main output enable is active, both output enables are 1 and the outputs follow `chRaw` and `chnRaw`. If both raw inputs are 1, both outputs are 0.
- R10: While disabled with idle-drive = 1, both output enables are 1 and the outputs take the shutdown levels. If both levels are 1, both outputs are 0.
- R11: While disabled with idle-drive = 0, both output enables are 0 and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register word select |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected word |
| extPin | input | 1 | External break pin |
| extEn | input | 1 | Pin source enable |
| extPol | input | 1 | Pin source active level |
| cmpIn | input | 1 | Comparator output |
| cmpEn | input | 1 | Comparator source enable |
| cmpPol | input | 1 | Comparator source active level |
| sysFault | input | 5 | System faults: lockup, supply monitor, parity, flash ECC, clock failure |
| chRaw | input | 1 | Raw channel drive |
| chnRaw | input | 1 | Raw complementary drive |
| outCh | output | 1 | Channel output level |
| outChN | output | 1 | Complementary output level |
| oeCh | output | 1 | Channel pin output enable |
| oeChN | output | 1 | Complementary pin output enable |

## Verification
The bench sweeps every combination of break enable, break polarity and the six pin and comparator controls. A design that inverts a source polarity, or that ignores polarity for an inactive source, would let outputs through during a break or block them when there is none. For filter settings 0 to 3, the bench drives assertions one sample short of the threshold and exactly at it. An off-by-one counter would either trip on the glitch or wait one cycle too long. The bench also tries to re-arm the output enable while a system fault is held. It checks the delayed readback of the control bits and of the output enable, and it feeds both-high raw inputs and both-high shutdown levels to confirm that the interlock never drives both outputs high.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int DATA_W = 8;
  localparam int N_SYS  = 5;

  typedef struct packed {
    logic outEnable;
    logic driveIdle;
    logic levelCh;
    logic levelChN;
  } dpCtrl_t;
endpackage

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
#(
  parameter int FILT_W = 4,
  parameter int NSYS   = N_SYS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              extPin,
  input  logic              extEn,
  input  logic              extPol,
  input  logic              cmpIn,
  input  logic              cmpEn,
  input  logic              cmpPol,
  input  logic [NSYS-1:0]   sysFault,
  output dpCtrl_t           dpCtrl,
  output logic              breakNow,
  output logic              moeReg,
  output logic              moeSync,
  output logic              flagQ
);
  localparam int CNT_W    = (1 << FILT_W) - 1;
  localparam int IDLE_BIT = 2 + FILT_W;

  logic              brkEn, brkPol, pendEn, pendPol;
  logic [FILT_W-1:0] filtSel;
  logic              driveIdle, levelCh, levelChN;
  logic              moeS1;
  logic [CNT_W-1:0]  holdCnt;
  logic [CNT_W:0]    limit;
  logic              srcAny, polHit, filtHit, moeEff;
  logic              wrCtrl, wrOut;

  assign wrCtrl = regWrEn && (regAddr == 1'b0);
  assign wrOut  = regWrEn && (regAddr == 1'b1);

  assign srcAny = (extEn & (extPin ~^ extPol)) | (cmpEn & (cmpIn ~^ cmpPol));
  assign polHit = brkPol ? srcAny : ~srcAny;

  // threshold = 2^filtSel samples, held count must reach threshold-1 before current sample
  assign limit   = ((CNT_W+1)'(1) << filtSel) - (CNT_W+1)'(1);
  assign filtHit = polHit && ({1'b0, holdCnt} >= limit);

  assign breakNow = brkEn & (filtHit | (|sysFault));
  assign moeEff   = moeReg & ~breakNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdCnt <= '0;
    else if (!polHit) holdCnt <= '0;
    else if (holdCnt != {CNT_W{1'b1}}) holdCnt <= holdCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendEn    <= 1'b0;
      pendPol   <= 1'b0;
      brkEn     <= 1'b0;
      brkPol    <= 1'b0;
      filtSel   <= '0;
      driveIdle <= 1'b0;
    end else begin
      brkEn  <= pendEn;
      brkPol <= pendPol;
      if (wrCtrl) begin
        pendEn    <= regWrData[0];
        pendPol   <= regWrData[1];
        filtSel   <= regWrData[2 +: FILT_W];
        driveIdle <= regWrData[IDLE_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      moeReg   <= 1'b0;
      flagQ    <= 1'b0;
      levelCh  <= 1'b0;
      levelChN <= 1'b0;
      moeS1    <= 1'b0;
      moeSync  <= 1'b0;
    end else begin
      moeS1   <= moeEff;
      moeSync <= moeS1;
      if (breakNow) moeReg <= 1'b0;
      else if (wrOut) moeReg <= regWrData[0];
      if (breakNow) flagQ <= 1'b1;
      else if (wrOut && regWrData[DATA_W-1]) flagQ <= 1'b0;
      if (wrOut) begin
        levelCh  <= regWrData[1];
        levelChN <= regWrData[2];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == 1'b0) begin
      regRdData[0]              = brkEn;
      regRdData[1]              = brkPol;
      regRdData[2 +: FILT_W]    = filtSel;
      regRdData[IDLE_BIT]       = driveIdle;
    end else begin
      regRdData[0]        = moeSync;
      regRdData[1]        = levelCh;
      regRdData[2]        = levelChN;
      regRdData[DATA_W-1] = flagQ;
    end
  end

  assign dpCtrl = '{outEnable: moeEff, driveIdle: driveIdle,
                    levelCh: levelCh, levelChN: levelChN};
endmodule

// File: rtl/guard_dp.sv
module guard_dp
  import guard_pkg::*;
(
  input  dpCtrl_t dpCtrl,
  input  logic    chRaw,
  input  logic    chnRaw,
  output logic    outCh,
  output logic    outChN,
  output logic    oeCh,
  output logic    oeChN
);
  logic selCh, selChN;

  always_comb begin
    if (dpCtrl.outEnable) begin
      selCh  = chRaw;
      selChN = chnRaw;
    end else begin
      selCh  = dpCtrl.levelCh;
      selChN = dpCtrl.levelChN;
    end
    // interlock: a both-high request drives both inactive
    outCh  = selCh & ~selChN;
    outChN = selChN & ~selCh;
    oeCh   = dpCtrl.outEnable | dpCtrl.driveIdle;
    oeChN  = dpCtrl.outEnable | dpCtrl.driveIdle;
    if (!oeCh) begin
      outCh  = 1'b0;
      outChN = 1'b0;
    end
  end
endmodule

// File: rtl/pwm_guard.sv
module pwm_guard
  import guard_pkg::*;
#(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              extPin,
  input  logic              extEn,
  input  logic              extPol,
  input  logic              cmpIn,
  input  logic              cmpEn,
  input  logic              cmpPol,
  input  logic [N_SYS-1:0]  sysFault,
  input  logic              chRaw,
  input  logic              chnRaw,
  output logic              outCh,
  output logic              outChN,
  output logic              oeCh,
  output logic              oeChN
);
  dpCtrl_t dpCtrl;
  logic    breakNow, moeReg, moeSync, flagQ;

  guard_ctrl #(.FILT_W(FILT_W), .NSYS(N_SYS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .extPin(extPin), .extEn(extEn), .extPol(extPol),
    .cmpIn(cmpIn), .cmpEn(cmpEn), .cmpPol(cmpPol), .sysFault(sysFault),
    .dpCtrl(dpCtrl), .breakNow(breakNow), .moeReg(moeReg),
    .moeSync(moeSync), .flagQ(flagQ)
  );

  guard_dp u_dp (
    .dpCtrl(dpCtrl), .chRaw(chRaw), .chnRaw(chnRaw),
    .outCh(outCh), .outChN(outChN), .oeCh(oeCh), .oeChN(oeChN)
  );
endmodule

// File: rtl/guard_chk.sv
module guard_chk (
  input logic clk,
  input logic rstN,
  input logic breakNow,
  input logic moeReg,
  input logic moeEff,
  input logic moeSync,
  input logic flagQ,
  input logic driveIdle,
  input logic regWrEn,
  input logic regAddr,
  input logic wrBit0,
  input logic outCh,
  input logic outChN,
  input logic oeCh,
  input logic oeChN
);
  assert_break_clears_moe_R5: assert property (@(posedge clk) disable iff (!rstN)
    breakNow |=> !moeReg);

  assert_break_sets_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    breakNow |=> flagQ);

  assert_no_rearm_in_break_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr && wrBit0 && breakNow) |=> !moeReg);

  assert_sync_delay_R8: assert property (@(posedge clk) disable iff (!rstN)
    moeSync == $past(moeEff, 2));

  assert_interlock_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(outCh && outChN));

  assert_idle_drive_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!moeEff && driveIdle) |-> (oeCh && oeChN));

  assert_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!moeEff && !driveIdle) |-> (!oeCh && !oeChN && !outCh && !outChN));
endmodule

bind pwm_guard guard_chk u_guard_chk (
  .clk(clk), .rstN(rstN), .breakNow(breakNow), .moeReg(moeReg),
  .moeEff(dpCtrl.outEnable), .moeSync(moeSync), .flagQ(flagQ),
  .driveIdle(dpCtrl.driveIdle), .regWrEn(regWrEn), .regAddr(regAddr),
  .wrBit0(regWrData[0]), .outCh(outCh), .outChN(outChN),
  .oeCh(oeCh), .oeChN(oeChN)
);

// File: tb/tb_pwm_guard.sv
module tb_pwm_guard;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0, regAddr = 1'b0;
  logic [7:0] regWrData = '0, regRdData;
  logic       extPin = 0, extEn = 0, extPol = 0, cmpIn = 0, cmpEn = 0, cmpPol = 0;
  logic [4:0] sysFault = '0;
  logic       chRaw = 0, chnRaw = 0;
  logic       outCh, outChN, oeCh, oeChN;
  int         checks = 0, failures = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  pwm_guard dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .extPin(extPin), .extEn(extEn), .extPol(extPol),
    .cmpIn(cmpIn), .cmpEn(cmpEn), .cmpPol(cmpPol), .sysFault(sysFault),
    .chRaw(chRaw), .chnRaw(chnRaw),
    .outCh(outCh), .outChN(outChN), .oeCh(oeCh), .oeChN(oeChN)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] d;
    logic       brk, srcAny;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rd(0, d); chk("R1 word0", d, 8'h00);
    rd(1, d); chk("R1 word1", d, 8'h00);
    chk("R1 oe", {oeCh, oeChN}, 2'b00);

    // R2 delayed enable/polarity
    wr(0, 8'h03);
    rd(0, d); chk("R2 old value", d & 8'h03, 8'h00);
    rd(0, d); chk("R2 new value", d & 8'h03, 8'h03);

    // R8 resynchronised readback
    wr(1, 8'h01);
    rd(1, d); chk("R8 edge1", d & 8'h01, 8'h00);
    rd(1, d); chk("R8 edge2", d & 8'h01, 8'h00);
    rd(1, d); chk("R8 edge3", d & 8'h01, 8'h01);

    // R9 pass-through with interlock
    for (int v = 0; v < 4; v++) begin
      @(negedge clk); chRaw = v[0]; chnRaw = v[1];
      #1 chk("R9 outputs", {oeCh, oeChN, outCh, outChN},
             {2'b11, v[0] & ~v[1], v[1] & ~v[0]});
    end

    // R11 released when disabled
    for (int v = 0; v < 4; v++) begin
      wr(1, {5'b0, v[1:0], 1'b0});
      @(negedge clk); chRaw = v[0]; chnRaw = v[1];
      #1 chk("R11 released", {oeCh, oeChN, outCh, outChN}, 4'b0000);
    end

    // R10 drive shutdown levels
    wr(0, 8'h43);
    for (int v = 0; v < 4; v++) begin
      wr(1, {5'b0, v[1:0], 1'b0});
      @(negedge clk); chRaw = 1'b1; chnRaw = 1'b1;
      #1 chk("R10 idle levels", {oeCh, oeChN, outCh, outChN},
             {2'b11, v[0] & ~v[1], v[1] & ~v[0]});
    end

    // R3 source combination sweep, observed through oeCh with idle release
    chRaw = 1'b1; chnRaw = 1'b0;
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      extEn = v[2]; extPol = v[3]; extPin = v[4];
      cmpEn = v[5]; cmpPol = v[6]; cmpIn = v[7];
      wr(0, {6'b0, v[1], v[0]});
      @(posedge clk);
      wr(1, 8'h01);
      srcAny = (v[2] & (v[4] == v[3])) | (v[5] & (v[7] == v[6]));
      brk = v[0] & (v[1] ? srcAny : ~srcAny);
      @(negedge clk); #1 chk("R3 source sweep", {7'b0, oeCh}, {7'b0, ~brk});
    end

    // R4 filter lengths for settings 0..3
    extEn = 1; extPol = 1; extPin = 0; cmpEn = 0;
    for (int f = 0; f < 4; f++) begin
      int n;
      n = 1 << f;
      wr(0, 8'(f << 2) | 8'h03);
      @(posedge clk);
      wr(1, 8'h81);
      if (n > 1) begin
        @(negedge clk); extPin = 1'b1;
        repeat (n - 2) @(negedge clk);
        #1 chk("R4 short glitch", {7'b0, oeCh}, 8'h01);
        extPin = 1'b0;
        @(negedge clk); #1 chk("R4 after glitch", {7'b0, oeCh}, 8'h01);
        rd(1, d); chk("R4 flag after glitch", d & 8'h80, 8'h00);
      end
      @(negedge clk); extPin = 1'b1;
      if (n > 1) begin
        repeat (n - 2) @(negedge clk);
        #1 chk("R4 before threshold", {7'b0, oeCh}, 8'h01);
        @(negedge clk);
      end
      #1 chk("R4 at threshold", {7'b0, oeCh}, 8'h00);
      extPin = 1'b0;
    end

    // R5 R6 R7 system faults
    extEn = 0;
    wr(0, 8'h03);
    @(posedge clk);
    for (int i = 0; i < 5; i++) begin
      wr(1, 8'h81);
      @(negedge clk); #1 chk("R5 enabled before fault", {7'b0, oeCh}, 8'h01);
      sysFault = 5'(1 << i);
      #1 chk("R5 same-cycle disable", {7'b0, oeCh}, 8'h00);
      rd(1, d); chk("R6 flag set", d & 8'h80, 8'h80);
      wr(1, 8'h01);
      @(negedge clk); sysFault = '0;
      #1 chk("R7 rearm blocked", {7'b0, oeCh}, 8'h00);
      repeat (2) @(posedge clk);
      rd(1, d); chk("R7 readback still off", d & 8'h01, 8'h00);
      wr(1, 8'h00);
      rd(1, d); chk("R6 write 0 keeps flag", d & 8'h80, 8'h80);
      wr(1, 8'h80);
      rd(1, d); chk("R6 write 1 clears", d & 8'h80, 8'h00);
    end

    // R3 break disabled ignores system faults
    wr(0, 8'h02);
    @(posedge clk);
    wr(1, 8'h81);
    @(negedge clk); sysFault = 5'h1f;
    #1 chk("R3 disabled ignores faults", {7'b0, oeCh}, 8'h01);
    rd(1, d); chk("R3 disabled no flag", d & 8'h80, 8'h00);
    sysFault = '0;

    finishRun();
  end
endmodule